// File: doc/BRIEF.md
# Cache Victim Way Selector

This block decides which way of an indexed cache set will take a newly fetched line after a miss. The tag and state lookup supplies the valid and dirty bits of every way in the set. The selector then returns a way number, a write-enable vector with one bit per way, and a flag that tells the miss handler whether the chosen line must be copied back to memory before it is overwritten. The result is combinational, so it is available in the same cycle as the request.

Empty ways are always taken first. If no way is empty, the choice falls on a clean line, and a global rotating pointer spreads these replacements across the ways. A modified line is only displaced when every way in the set holds one. In that case the pointer's way is taken and the write-back flag is raised. The pointer moves only when it actually made the choice, and either a reset or a synchronous flush returns it to way 0.

Top module: `victim_way_sel`

## Requirements
- R1: When `req_i` is high and at least one way has valid bit 0, `victim_o` is the lowest-numbered such way and `wb_needed_o` is 0.
- R2: When every way is valid and at least one is clean (dirty bit 0), `victim_o` is the first clean way found by scanning upward from the pointer value and wrapping from way WAYS-1 to way 0. `wb_needed_o` is 0.
- R3: A way that is both valid and dirty is never reported as the victim while any invalid or clean way exists in the set.
- R4: When every way is valid and dirty, `victim_o` equals the pointer value and `wb_needed_o` is 1 (only while `req_i` is high).
- R5: `way_we_o` is all zeros while `req_i` is low. While `req_i` is high it has exactly one bit set, at bit position `victim_o`, in the same cycle as the request.
- R6: At a clock edge with `req_i` high, the pointer becomes (victim+1) mod WAYS if the victim was chosen under R2 or R4. The pointer is unchanged if the victim was chosen under R1 or if `req_i` is low.
- R7: The pointer is 0 after `rst_n` is low. It is also 0 after any clock edge with `flush_i` high, and this takes priority over a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous pointer clear |
| req_i | input | 1 | Replacement request; commits the choice at the clock edge |
| valid_i | input | WAYS | Valid bit of each way in the indexed set |
| dirty_i | input | WAYS | Dirty bit of each way in the indexed set |
| victim_o | output | $clog2(WAYS) | Chosen way number |
| way_we_o | output | WAYS | One-hot write enable for the chosen way |
| wb_needed_o | output | 1 | Chosen line must be written back first |

## Verification
The only hidden state is the rotating pointer, and it is visible in any all-dirty request, where the victim is the pointer itself. A pointer that is wrong by one step shows up as the wrong victim at the next clean-way or all-dirty request. The bench therefore follows every pointer-moving or pointer-holding sequence with a probe, so a missed advance, an advance that should not have happened, or a flush that did not clear the pointer appears one cycle after it occurs. Errors in the filtering logic appear in the same cycle as the request, as a dirty victim or a raised write-back flag.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  typedef enum logic [1:0] {
    SRC_FREE  = 2'd0,
    SRC_CLEAN = 2'd1,
    SRC_DIRTY = 2'd2
  } pick_src_e;
endpackage

// File: rtl/vsel_lowest_free.sv
module vsel_lowest_free #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid,
  output logic             found,
  output logic [WAY_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        found = 1'b1;
        idx   = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/vsel_rr_clean.sv
module vsel_rr_clean #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  cand,
  input  logic [WAY_W-1:0] start,
  output logic             found,
  output logic [WAY_W-1:0] idx
);
  // wrap an offset from start into the way range
  function automatic int wrap_way(input logic [WAY_W-1:0] base, input int off);
    int s;
    s = int'(base) + off;
    if (s >= WAYS) s = s - WAYS;
    return s;
  endfunction

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = WAYS - 1; k >= 0; k--) begin
      if (cand[wrap_way(start, k)]) begin
        found = 1'b1;
        idx   = WAY_W'(wrap_way(start, k));
      end
    end
  end
endmodule

// File: rtl/vsel_rr_ptr.sv
module vsel_rr_ptr #(
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             adv,
  input  logic [WAY_W-1:0] next_val,
  output logic [WAY_W-1:0] ptr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (flush) ptr_q <= '0;
    else if (adv)   ptr_q <= next_val;
  end
endmodule

// File: rtl/vsel_way_dec.sv
module vsel_way_dec #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             en,
  input  logic [WAY_W-1:0] idx,
  output logic [WAYS-1:0]  onehot
);
  for (genvar g = 0; g < WAYS; g++) begin : g_dec
    assign onehot[g] = en && (idx == WAY_W'(g));
  end
endmodule

// File: rtl/victim_way_sel.sv
module victim_way_sel #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             req_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAYS-1:0]  dirty_i,
  output logic [WAY_W-1:0] victim_o,
  output logic [WAYS-1:0]  way_we_o,
  output logic             wb_needed_o
);
  import vsel_pkg::*;

  function automatic logic [WAY_W-1:0] step_way(input logic [WAY_W-1:0] w);
    return (int'(w) == WAYS - 1) ? '0 : w + 1'b1;
  endfunction

  logic [WAYS-1:0]  clean_vec;
  logic             free_found, clean_found;
  logic [WAY_W-1:0] free_idx, clean_idx, ptr_q, ptr_next;
  pick_src_e        src;
  logic             ptr_adv;

  assign clean_vec = valid_i & ~dirty_i;

  vsel_lowest_free #(.WAYS(WAYS), .WAY_W(WAY_W)) u_free (
    .valid(valid_i), .found(free_found), .idx(free_idx));

  vsel_rr_clean #(.WAYS(WAYS), .WAY_W(WAY_W)) u_clean (
    .cand(clean_vec), .start(ptr_q), .found(clean_found), .idx(clean_idx));

  always_comb begin
    if (free_found)       src = SRC_FREE;
    else if (clean_found) src = SRC_CLEAN;
    else                  src = SRC_DIRTY;
  end

  always_comb begin
    case (src)
      SRC_FREE:  victim_o = free_idx;
      SRC_CLEAN: victim_o = clean_idx;
      default:   victim_o = ptr_q;
    endcase
  end

  assign wb_needed_o = req_i && (src == SRC_DIRTY);
  assign ptr_adv     = req_i && (src != SRC_FREE);
  assign ptr_next    = step_way(victim_o);

  vsel_rr_ptr #(.WAY_W(WAY_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .flush(flush_i), .adv(ptr_adv),
    .next_val(ptr_next), .ptr_q(ptr_q));

  vsel_way_dec #(.WAYS(WAYS), .WAY_W(WAY_W)) u_dec (
    .en(req_i), .idx(victim_o), .onehot(way_we_o));
endmodule

// File: rtl/victim_way_sel_chk.sv
module victim_way_sel_chk #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_i,
  input logic             req_i,
  input logic [WAYS-1:0]  valid_i,
  input logic [WAYS-1:0]  dirty_i,
  input logic [WAY_W-1:0] victim_o,
  input logic [WAYS-1:0]  way_we_o,
  input logic             wb_needed_o,
  input logic [WAY_W-1:0] ptr_q,
  input logic             ptr_adv
);
  logic any_free, any_clean;
  logic [WAY_W-1:0] exp_next;
  assign any_free  = |(~valid_i);
  assign any_clean = |(valid_i & ~dirty_i);
  assign exp_next  = (int'(victim_o) == WAYS - 1) ? '0 : victim_o + 1'b1;

  assert_free_not_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && any_free) |-> (!valid_i[victim_o] && !wb_needed_o));

  assert_no_dirty_victim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && (any_free || any_clean)) |-> !(valid_i[victim_o] && dirty_i[victim_o]));

  assert_wb_only_all_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_needed_o |-> (req_i && (&valid_i) && (&dirty_i) && victim_o == ptr_q));

  assert_we_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |-> (way_we_o == '0));

  assert_we_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |-> ($countones(way_we_o) == 1 && way_we_o[victim_o]));

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !(req_i && !any_free)) |=> $stable(ptr_q));

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && ptr_adv) |=> (ptr_q == $past(exp_next)));

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (ptr_q == '0));
endmodule

bind victim_way_sel victim_way_sel_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .req_i(req_i),
  .valid_i(valid_i), .dirty_i(dirty_i), .victim_o(victim_o),
  .way_we_o(way_we_o), .wb_needed_o(wb_needed_o),
  .ptr_q(ptr_q), .ptr_adv(ptr_adv));

// File: tb/victim_way_sel_tb_top.sv
module victim_way_sel_tb_top;
  localparam int WAYS = 4;
  localparam int WAY_W = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             flush_i = 1'b0;
  logic             req_i = 1'b0;
  logic [WAYS-1:0]  valid_i = '0;
  logic [WAYS-1:0]  dirty_i = '0;
  logic [WAY_W-1:0] victim_o;
  logic [WAYS-1:0]  way_we_o;
  logic             wb_needed_o;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_ptr = 0;

  always #10 clk = ~clk;

  victim_way_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .req_i(req_i),
    .valid_i(valid_i), .dirty_i(dirty_i), .victim_o(victim_o),
    .way_we_o(way_we_o), .wb_needed_o(wb_needed_o));

  task automatic check(input string rq, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // reference: returns victim, sets wb and whether the pointer moves
  function automatic int ref_pick(input logic [WAYS-1:0] v, input logic [WAYS-1:0] d,
                                  output bit wb, output bit moves);
    wb = 0; moves = 0;
    for (int i = 0; i < WAYS; i++) if (!v[i]) return i;
    moves = 1;
    for (int k = 0; k < WAYS; k++) begin
      int w = (exp_ptr + k) % WAYS;
      if (!d[w]) return w;
    end
    wb = 1;
    return exp_ptr;
  endfunction

  // drive at falling edge, check mid-cycle, commit at the next rising edge
  task automatic apply(input logic [WAYS-1:0] v, input logic [WAYS-1:0] d,
                       input bit rq, input string tag);
    int ev; bit ewb, mv;
    @(negedge clk);
    valid_i = v; dirty_i = d; req_i = rq;
    #1;
    ev = ref_pick(v, d, ewb, mv);
    check({tag, " victim"}, int'(victim_o), ev);
    check({tag, " wb R4"}, int'(wb_needed_o), rq ? int'(ewb) : 0);
    check({tag, " we R5"}, int'(way_we_o), rq ? (1 << ev) : 0);
    if (rq && mv) exp_ptr = (ev + 1) % WAYS;
  endtask

  task automatic probe_ptr(input string tag);
    apply('1, '1, 1'b0, {tag, " ptr probe R6"});
  endtask

  task automatic t_reset;
    probe_ptr("R7 reset");
    check("R7 reset ptr", int'(victim_o), 0);
  endtask

  task automatic t_free;
    apply(4'b1011, 4'b1011, 1'b1, "R1 one free");
    apply(4'b0110, 4'b0000, 1'b1, "R1 low free");
    apply(4'b0000, 4'b1111, 1'b1, "R1 all free");
    apply(4'b0111, 4'b0111, 1'b1, "R1 top free");
    probe_ptr("R6 free no advance");
  endtask

  task automatic t_clean;
    apply(4'b1111, 4'b0001, 1'b1, "R2 clean skip R3");
    apply(4'b1111, 4'b0000, 1'b1, "R2 all clean");
    apply(4'b1111, 4'b1000, 1'b1, "R2 wrap R3");
    apply(4'b1111, 4'b1101, 1'b1, "R3 single clean");
    probe_ptr("R6 after clean");
  endtask

  task automatic t_all_dirty;
    for (int i = 0; i < WAYS + 1; i++) apply('1, '1, 1'b1, "R4 all dirty");
    probe_ptr("R6 after dirty wrap");
  endtask

  task automatic t_noreq;
    apply(4'b1111, 4'b0000, 1'b0, "R5 idle");
    apply(4'b1111, 4'b0011, 1'b0, "R5 idle two");
    probe_ptr("R6 idle hold");
  endtask

  task automatic t_flush;
    apply('1, '1, 1'b1, "R4 pre flush");
    @(negedge clk);
    flush_i = 1'b1; req_i = 1'b1; valid_i = '1; dirty_i = 4'b0000;
    @(negedge clk);
    flush_i = 1'b0; req_i = 1'b0;
    exp_ptr = 0;
    probe_ptr("R7 flush");
    check("R7 flush ptr", int'(victim_o), 0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_free();
    t_clean();
    t_all_dirty();
    t_noreq();
    t_flush();
    t_clean();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule